// File: doc/BRIEF.md
# Chip-Select Framed Serial Sample Receiver

This block accepts 8-bit two's-complement audio samples from a host over a three-wire, write-only serial link. The link has a data line, a shift clock and an active-low select. Bits are shifted in on shift-clock rising edges while the select is low, most significant bit first. A word is complete on the eighth edge of a frame. A frame is delimited by the select line, and the rate of select falling edges sets the sample rate, nominally 8 to 80 kHz.

Completed words cross into an unrelated master-clock domain (nominally 0.5 to 3 MHz) through a double buffer. The shift side holds the finished word in its own register and flips a toggle flag. The master side resynchronizes that flag, copies the word into an output register, and raises a one-cycle valid strobe. A returned acknowledge flag keeps the shift-side buffer from being rewritten while a transfer is still pending.

A frame cut short by the select rising early is discarded, and the previous sample stays on the output. The master side also measures, in master-clock cycles, the spacing between consecutive valid strobes, so downstream logic knows the current sample period.

Top module: `cssr_top`

## Requirements
- R1: While `rst_n_i` is low, `sample_o` is 0x00, `sample_valid_o` is 0 and `period_o` is 0, independent of any clock.
- R2: The first bit sampled after `sel_n_i` falls becomes bit 7 of the word and the eighth becomes bit 0, so 0x5A, 0x80 (-128), 0x7F (+127), 0x01, 0xC3, 0xA5 and 0xFF arrive unchanged.
- R3: A word is committed on the eighth rising `sclk_i` edge of a frame and appears on `sample_o`, and `sample_o` changes only in a cycle where `sample_valid_o` is 1.
- R4: Rising `sclk_i` edges after the eighth in the same frame change neither the committed word nor cause another strobe.
- R5: If `sel_n_i` rises after fewer than eight bits, no strobe is issued and `sample_o` keeps the last committed value.
- R6: Each falling `sel_n_i` restarts the bit count at zero, so a complete frame following an aborted one is decoded correctly.
- R7: `sample_valid_o` is high for exactly one `mclk_i` cycle, once for each committed word.
- R8: In each cycle `sample_valid_o` is 1, `period_o` takes the number of `mclk_i` cycles since the previous strobe. It reads 0 until two strobes have occurred after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset for both domains |
| sclk_i | input | 1 | Serial shift clock from the host |
| sdata_i | input | 1 | Serial data, sampled on `sclk_i` rising edges |
| sel_n_i | input | 1 | Active-low frame select |
| mclk_i | input | 1 | Master clock of the output domain |
| sample_o | output | WIDTH (8) | Last committed two's-complement sample |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |
| period_o | output | PERIOD_W (16) | Strobe-to-strobe spacing in master cycles |

## Verification
On every cycle, the assertions check the following:
- the strobe is one cycle wide;
- the output word changes only under the strobe;
- the bit counter stays at or below the word length;
- the shift-side toggle flips only on the last bit of a frame;
- the period reads zero before two strobes.

Only the bench scenarios can show that the bit order and the values are right across the domain crossing. The same holds for aborted frames leaving the old sample in place, for surplus shift edges doing nothing, and for a steady frame spacing yielding the expected period count.

// File: rtl/cssr_pkg.sv
package cssr_pkg;
   parameter int unsigned CSSR_WORD_W   = 8;
   parameter int unsigned CSSR_PERIOD_W = 16;
   parameter int unsigned CSSR_SYNC_N   = 2;
endpackage

// File: rtl/cssr_sync.sv
module cssr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cssr_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk_i or negedge rst_n_i)
            if (!rst_n_i) chain_q <= '0;
            else          chain_q <= {chain_q[0], d_i};
      end else begin : g_deep
         always_ff @(posedge clk_i or negedge rst_n_i)
            if (!rst_n_i) chain_q <= '0;
            else          chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cssr_shift.sv
module cssr_shift #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             rst_n_i,
   input  logic             sclk_i,
   input  logic             sdata_i,
   input  logic             sel_n_i,
   input  logic             ack_tgl_i,
   output logic [WIDTH-1:0] word_o,
   output logic             tgl_o
);
   localparam int unsigned CNT_W = $clog2(WIDTH + 1);
   localparam int unsigned SH_W  = WIDTH - 1;

   logic             frame_clr;
   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  sh_q;
   logic [WIDTH-1:0] hold_q;
   logic             tgl_q;
   logic             ack_s;
   logic             last_bit;

   assign frame_clr = !rst_n_i || sel_n_i;
   assign last_bit  = (cnt_q == CNT_W'(WIDTH - 1));

   // bit counter and partial word, cleared whenever select is high
   always_ff @(posedge sclk_i or posedge frame_clr)
      if (frame_clr) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (cnt_q != CNT_W'(WIDTH)) begin
         cnt_q <= cnt_q + 1'b1;
         sh_q  <= SH_W'({sh_q, sdata_i});
      end

   cssr_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk_i   (sclk_i),
      .rst_n_i (rst_n_i),
      .d_i     (ack_tgl_i),
      .q_o     (ack_s)
   );

   // shift-side buffer: written only when the previous word was taken
   always_ff @(posedge sclk_i or negedge rst_n_i)
      if (!rst_n_i) begin
         hold_q <= '0;
         tgl_q  <= 1'b0;
      end else if (!sel_n_i && last_bit && (ack_s == tgl_q)) begin
         hold_q <= {sh_q, sdata_i};
         tgl_q  <= ~tgl_q;
      end

   assign word_o = hold_q;
   assign tgl_o  = tgl_q;

   p_cnt_bound_r4: assert property (@(posedge sclk_i) disable iff (frame_clr)
      cnt_q <= CNT_W'(WIDTH));

   p_commit_last_bit_r3: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
      (tgl_q != $past(tgl_q)) |-> ($past(cnt_q) == CNT_W'(WIDTH - 1)));
endmodule

// File: rtl/cssr_period.sv
module cssr_period #(
   parameter int unsigned W        = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         strobe_i,
   output logic [W-1:0] period_o
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nxt;
   logic         seen_q;

   generate
      if (W < 2) begin : g_bad
         $error("cssr_period: W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt_q == {W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i)
      if (!rst_n_i) begin
         cnt_q    <= '0;
         seen_q   <= 1'b0;
         period_o <= '0;
      end else if (strobe_i) begin
         cnt_q  <= W'(1);
         seen_q <= 1'b1;
         if (seen_q) period_o <= cnt_q;
      end else begin
         cnt_q <= cnt_nxt;
      end

   p_period_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !seen_q |-> (period_o == '0));
endmodule

// File: rtl/cssr_top.sv
module cssr_top
   import cssr_pkg::*;
#(
   parameter int unsigned WIDTH    = CSSR_WORD_W,
   parameter int unsigned PERIOD_W = CSSR_PERIOD_W,
   parameter int unsigned STAGES   = CSSR_SYNC_N
) (
   input  logic                rst_n_i,
   input  logic                sclk_i,
   input  logic                sdata_i,
   input  logic                sel_n_i,
   input  logic                mclk_i,
   output logic [WIDTH-1:0]    sample_o,
   output logic                sample_valid_o,
   output logic [PERIOD_W-1:0] period_o
);
   generate
      if (WIDTH < 2) begin : g_bad_w
         $error("cssr_top: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] frame_word;
   logic             frame_tgl;
   logic             tgl_sync;
   logic             tgl_seen_q;
   logic             new_word;

   cssr_shift #(.WIDTH(WIDTH), .STAGES(STAGES)) u_shift (
      .rst_n_i   (rst_n_i),
      .sclk_i    (sclk_i),
      .sdata_i   (sdata_i),
      .sel_n_i   (sel_n_i),
      .ack_tgl_i (tgl_seen_q),
      .word_o    (frame_word),
      .tgl_o     (frame_tgl)
   );

   cssr_sync #(.STAGES(STAGES)) u_tgl_sync (
      .clk_i   (mclk_i),
      .rst_n_i (rst_n_i),
      .d_i     (frame_tgl),
      .q_o     (tgl_sync)
   );

   assign new_word = tgl_sync ^ tgl_seen_q;

   // master-side buffer
   always_ff @(posedge mclk_i or negedge rst_n_i)
      if (!rst_n_i) begin
         tgl_seen_q     <= 1'b0;
         sample_o       <= '0;
         sample_valid_o <= 1'b0;
      end else begin
         tgl_seen_q     <= tgl_sync;
         sample_valid_o <= new_word;
         if (new_word) sample_o <= frame_word;
      end

   cssr_period #(.W(PERIOD_W), .SATURATE(1'b1)) u_period (
      .clk_i    (mclk_i),
      .rst_n_i  (rst_n_i),
      .strobe_i (new_word),
      .period_o (period_o)
   );

   p_valid_single_r7: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      sample_valid_o |=> !sample_valid_o);

   p_sample_hold_r3: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      !$stable(sample_o) |-> sample_valid_o);
endmodule

// File: tb/cssr_top_test.sv
`timescale 1ns/1ps
module cssr_top_test;
   logic        rst_n_i = 1'b0;
   logic        sclk_i  = 1'b0;
   logic        sdata_i = 1'b0;
   logic        sel_n_i = 1'b1;
   logic        mclk_i  = 1'b0;
   logic [7:0]  sample_o;
   logic        sample_valid_o;
   logic [15:0] period_o;

   int n_checks = 0;
   int n_fail   = 0;
   int n_valid  = 0;
   int last_period = 0;
   logic [7:0] exp_q[$];

   always #2.5 mclk_i = ~mclk_i;   // 200 MHz

   cssr_top uut (
      .rst_n_i(rst_n_i), .sclk_i(sclk_i), .sdata_i(sdata_i), .sel_n_i(sel_n_i),
      .mclk_i(mclk_i), .sample_o(sample_o), .sample_valid_o(sample_valid_o),
      .period_o(period_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // driver: one frame; nbits data bits then extra surplus edges
   task automatic send_frame(input logic [7:0] v, input int nbits, input int extra);
      sel_n_i = 1'b0;
      #20;
      for (int i = 0; i < nbits; i++) begin
         sdata_i = v[7-i];
         #10 sclk_i = 1'b1;
         if (i == 7) exp_q.push_back(v);
         #10 sclk_i = 1'b0;
      end
      for (int k = 0; k < extra; k++) begin
         sdata_i = ~sdata_i;
         #10 sclk_i = 1'b1;
         #10 sclk_i = 1'b0;
      end
      #10 sel_n_i = 1'b1;
      #10;
   endtask

   // fixed 800 ns frame pitch -> 160 master cycles
   task automatic send_spaced(input logic [7:0] v);
      send_frame(v, 8, 0);
      #600;
   endtask

   // monitor / scoreboard
   always @(negedge mclk_i) begin
      if (rst_n_i && sample_valid_o) begin
         n_valid++;
         last_period = int'(period_o);
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 strobe without committed word", int'(sample_o), 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(sample_o == e, "R2/R3 received word", int'(sample_o), int'(e));
         end
      end
   end

   task automatic finish_run();
      check(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #200000;
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int nv;
      #20;
      check(sample_o == 8'h00, "R1 reset sample", int'(sample_o), 0);
      check(sample_valid_o == 1'b0, "R1 reset strobe", int'(sample_valid_o), 0);
      check(period_o == 16'd0, "R1 reset period", int'(period_o), 0);
      #33 rst_n_i = 1'b1;
      #47;

      send_frame(8'h5A, 8, 0);
      #100;
      check(period_o == 16'd0, "R8 period zero after first strobe", int'(period_o), 0);

      send_spaced(8'h80);
      send_spaced(8'h7F);
      send_spaced(8'h01);
      check(last_period == 160, "R8 period of 800 ns frames", last_period, 160);
      check(sample_o == 8'h01, "R2 last word on output", int'(sample_o), 8'h01);

      nv = n_valid;
      send_frame(8'h33, 3, 0);  // R5 abort
      #200;
      check(sample_o == 8'h01, "R5 aborted frame keeps sample", int'(sample_o), 8'h01);
      check(n_valid == nv, "R5 no strobe on abort", n_valid, nv);

      send_frame(8'hC3, 8, 0);  // R6 full frame after abort
      #200;
      check(sample_o == 8'hC3, "R6 frame after abort", int'(sample_o), 8'hC3);

      nv = n_valid;
      send_frame(8'hA5, 8, 4);  // R4 surplus edges
      #200;
      check(sample_o == 8'hA5, "R4 surplus edges ignored", int'(sample_o), 8'hA5);
      check(n_valid == nv + 1, "R7 one strobe per word", n_valid, nv + 1);

      rst_n_i = 1'b0;
      #12;
      check(sample_o == 8'h00, "R1 reset clears sample", int'(sample_o), 0);
      check(period_o == 16'd0, "R1 reset clears period", int'(period_o), 0);
      #13 rst_n_i = 1'b1;
      #50;

      send_frame(8'hFF, 8, 0);
      #200;
      check(sample_o == 8'hFF, "R2 all-ones word after reset", int'(sample_o), 8'hFF);
      check(period_o == 16'd0, "R8 period zero after reset", int'(period_o), 0);

      finish_run();
   end
endmodule